// File: doc/BRIEF.md
# Dual-Orientation SIMD Context Store

This block holds the configuration words for an 8x8 grid of reconfigurable cells. It has two halves of storage. The row half feeds the rows of the grid and the column half feeds the columns. Each half keeps one group of context words for each of its eight lines. Each group holds sixteen words, selected by a 4-bit index.

A host write port loads single words into either half. The broadcast port chooses a half, a line and an index. One cycle later the block presents the selected word on all eight lanes of that line, together with a one-hot line mask, so every cell on the line receives the same configuration.

The write port and the broadcast port are independent and may both be used in the same cycle. This lets new contexts be loaded while the grid is being configured from other words. When both ports address the same word in the same cycle, the broadcast reads the word that was stored before the write.

Top module: `ctx_broadcast_ctrl`

## Requirements
- R1: A word written with `wr_en` high is stored at the location given by half, line and index, and a later broadcast of that location returns it.
- R2: A broadcast request taken at a clock edge produces, after the next clock edge, `out_valid` high, `out_orient` equal to the requested half (0 = rows, 1 = columns), and `out_mask` with only bit number `bc_line` set.
- R3: While `out_valid` is high, all eight lanes of `out_words` carry the same word. Lane k occupies bits [32k+31:32k].
- R4: The row half and the column half are separate: a write to one half never changes the word at the same line and index in the other half.
- R5: Within a half, each line and each index is a separate word: a write changes no neighbouring line or index.
- R6: A write and a broadcast to different locations in the same cycle both take effect. The broadcast returns its stored word, and the written word is readable afterwards.
- R7: When a write and a broadcast address the same half, line and index in the same cycle, the broadcast returns the old word. A broadcast one cycle later returns the new word.
- R8: In a cycle following one with `bc_en` low, `out_valid` is low and `out_mask` is all zeros.
- R9: Reset clears `out_valid` and `out_mask`, including when a broadcast request is pending at the reset edge.
- R10: With `wr_en` low, the write address and data inputs change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one context word |
| wr_orient | input | 1 | Half to write: 0 rows, 1 columns |
| wr_line | input | 3 | Line (group) to write |
| wr_idx | input | 4 | Context index to write |
| wr_data | input | 32 | Context word to store |
| bc_en | input | 1 | Broadcast request |
| bc_orient | input | 1 | Half to broadcast from: 0 rows, 1 columns |
| bc_line | input | 3 | Line to drive |
| bc_idx | input | 4 | Context index to broadcast |
| out_valid | output | 1 | Broadcast result valid |
| out_orient | output | 1 | Half of the current result |
| out_mask | output | 8 | One-hot mask of the driven line |
| out_words | output | 256 | Eight copies of the broadcast word |

## Verification
The bench pairs a row word and a column word at the same line and index, and neighbouring lines and indices, with distinct data. A design that folded the two halves together, or dropped an address bit, would return the wrong one of the pair.

A same-address write and broadcast in one cycle exposes a write-first memory, which would hand the new word out a cycle early. A simultaneous write elsewhere catches a design that stalls or loses one port.

A write attempt with the strobe low, an idle cycle, and a reset arriving with a request pending cover a memory that ignores its enable, a valid that lingers after the request ends, and a mask that survives reset.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int unsigned DEF_LINES  = 8;
    localparam int unsigned DEF_CTXS   = 16;
    localparam int unsigned DEF_WORD_W = 32;

    typedef enum logic {
        ORIENT_ROW = 1'b0,
        ORIENT_COL = 1'b1
    } orient_e;
endpackage

// File: rtl/ctx_bank.sv
module ctx_bank #(
    parameter int unsigned LINES  = ctx_pkg::DEF_LINES,
    parameter int unsigned CTXS   = ctx_pkg::DEF_CTXS,
    parameter int unsigned WORD_W = ctx_pkg::DEF_WORD_W,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned IDX_W  = $clog2(CTXS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    localparam int unsigned DEPTH  = LINES * CTXS;
    localparam int unsigned ADDR_W = LINE_W + IDX_W;

    logic [WORD_W-1:0] store [DEPTH];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign wr_addr = {wr_line, wr_idx};
    assign rd_addr = {rd_line, rd_idx};

    // Separate write and read ports; nonblocking update gives read-old on collision.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end
endmodule

// File: rtl/ctx_fanout.sv
module ctx_fanout #(
    parameter int unsigned LINES  = ctx_pkg::DEF_LINES,
    parameter int unsigned WORD_W = ctx_pkg::DEF_WORD_W,
    localparam int unsigned LINE_W = $clog2(LINES)
) (
    input  logic                    valid,
    input  logic [LINE_W-1:0]       line,
    input  logic [WORD_W-1:0]       word,
    output logic [LINES-1:0]        mask,
    output logic [LINES*WORD_W-1:0] words
);
    for (genvar g = 0; g < LINES; g++) begin : g_lane
        assign words[g*WORD_W +: WORD_W] = word;
        assign mask[g] = valid && (line == LINE_W'(g));
    end
endmodule

// File: rtl/ctx_broadcast_ctrl.sv
module ctx_broadcast_ctrl #(
    parameter int unsigned LINES  = ctx_pkg::DEF_LINES,
    parameter int unsigned CTXS   = ctx_pkg::DEF_CTXS,
    parameter int unsigned WORD_W = ctx_pkg::DEF_WORD_W,
    localparam int unsigned LINE_W = $clog2(LINES),
    localparam int unsigned IDX_W  = $clog2(CTXS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    wr_orient,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    bc_en,
    input  logic                    bc_orient,
    input  logic [LINE_W-1:0]       bc_line,
    input  logic [IDX_W-1:0]        bc_idx,
    output logic                    out_valid,
    output logic                    out_orient,
    output logic [LINES-1:0]        out_mask,
    output logic [LINES*WORD_W-1:0] out_words
);
    import ctx_pkg::*;

    localparam int unsigned HALVES = 2;

    typedef struct packed {
        logic              valid;
        orient_e           orient;
        logic [LINE_W-1:0] line;
    } stage_t;

    stage_t            st_q;
    logic [WORD_W-1:0] half_q [HALVES];
    logic [WORD_W-1:0] sel_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.valid  <= bc_en;
            st_q.orient <= orient_e'(bc_orient);
            st_q.line   <= bc_line;
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam logic SIDE = 1'(h);
        ctx_bank #(
            .LINES  (LINES),
            .CTXS   (CTXS),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk     (clk),
            .wr_en   (wr_en && (wr_orient == SIDE)),
            .wr_line (wr_line),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_en   (bc_en && (bc_orient == SIDE)),
            .rd_line (bc_line),
            .rd_idx  (bc_idx),
            .rd_data (half_q[h])
        );
    end

    assign sel_word   = (st_q.orient == ORIENT_COL) ? half_q[1] : half_q[0];
    assign out_valid  = st_q.valid;
    assign out_orient = st_q.orient;

    ctx_fanout #(
        .LINES  (LINES),
        .WORD_W (WORD_W)
    ) u_fanout (
        .valid (st_q.valid),
        .line  (st_q.line),
        .word  (sel_word),
        .mask  (out_mask),
        .words (out_words)
    );
endmodule

// File: rtl/ctx_broadcast_chk.sv
module ctx_broadcast_chk #(
    parameter int unsigned LINES  = ctx_pkg::DEF_LINES,
    parameter int unsigned WORD_W = ctx_pkg::DEF_WORD_W,
    localparam int unsigned LINE_W = $clog2(LINES)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bc_en,
    input logic                    bc_orient,
    input logic [LINE_W-1:0]       bc_line,
    input logic                    out_valid,
    input logic                    out_orient,
    input logic [LINES-1:0]        out_mask,
    input logic [LINES*WORD_W-1:0] out_words
);
    logic lanes_same;

    always_comb begin
        lanes_same = 1'b1;
        for (int k = 1; k < LINES; k++) begin
            if (out_words[k*WORD_W +: WORD_W] != out_words[WORD_W-1:0]) begin
                lanes_same = 1'b0;
            end
        end
    end

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        bc_en |=> out_valid);

    p_mask_line_r2: assert property (@(posedge clk) disable iff (rst)
        bc_en |=> (out_mask == (LINES'(1) << $past(bc_line))));

    p_orient_echo_r2: assert property (@(posedge clk) disable iff (rst)
        bc_en |=> (out_orient == $past(bc_orient)));

    p_mask_single_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_mask) == 1));

    p_lanes_equal_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lanes_same);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !bc_en |=> (!out_valid && (out_mask == '0)));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!out_valid && (out_mask == '0)));
endmodule

bind ctx_broadcast_ctrl ctx_broadcast_chk #(
    .LINES  (LINES),
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bc_en      (bc_en),
    .bc_orient  (bc_orient),
    .bc_line    (bc_line),
    .out_valid  (out_valid),
    .out_orient (out_orient),
    .out_mask   (out_mask),
    .out_words  (out_words)
);

// File: tb/sim_ctx_broadcast_ctrl.sv
module sim_ctx_broadcast_ctrl;
    localparam int unsigned LINES  = 8;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NVEC   = 12;

    typedef struct packed {
        logic        o;
        logic [2:0]  l;
        logic [3:0]  i;
        logic [31:0] d;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 3'd0, 4'd0,  32'hA000_0000},
        '{1'b1, 3'd0, 4'd0,  32'hB000_0001},
        '{1'b0, 3'd3, 4'd5,  32'h1234_5678},
        '{1'b1, 3'd3, 4'd5,  32'h8765_4321},
        '{1'b0, 3'd4, 4'd5,  32'hC0DE_0405},
        '{1'b0, 3'd3, 4'd6,  32'hC0DE_0306},
        '{1'b0, 3'd7, 4'd15, 32'hFFFF_FFFF},
        '{1'b1, 3'd7, 4'd15, 32'h0000_0000},
        '{1'b1, 3'd7, 4'd0,  32'h5A5A_5A5A},
        '{1'b0, 3'd0, 4'd15, 32'hDEAD_BEEF},
        '{1'b1, 3'd2, 4'd9,  32'h0F0F_F0F0},
        '{1'b0, 3'd6, 4'd1,  32'h1357_9BDF}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    wr_en = 1'b0;
    logic                    wr_orient = 1'b0;
    logic [2:0]              wr_line = '0;
    logic [3:0]              wr_idx = '0;
    logic [31:0]             wr_data = '0;
    logic                    bc_en = 1'b0;
    logic                    bc_orient = 1'b0;
    logic [2:0]              bc_line = '0;
    logic [3:0]              bc_idx = '0;
    logic                    out_valid;
    logic                    out_orient;
    logic [LINES-1:0]        out_mask;
    logic [LINES*WORD_W-1:0] out_words;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctx_broadcast_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_orient  (wr_orient),
        .wr_line    (wr_line),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .bc_en      (bc_en),
        .bc_orient  (bc_orient),
        .bc_line    (bc_line),
        .bc_idx     (bc_idx),
        .out_valid  (out_valid),
        .out_orient (out_orient),
        .out_mask   (out_mask),
        .out_words  (out_words)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_write(input logic o, input logic [2:0] l, input logic [3:0] i, input logic [31:0] d);
        wr_en = 1'b1; wr_orient = o; wr_line = l; wr_idx = i; wr_data = d;
    endtask

    task automatic set_bcast(input logic o, input logic [2:0] l, input logic [3:0] i);
        bc_en = 1'b1; bc_orient = o; bc_line = l; bc_idx = i;
    endtask

    // After one edge with the current inputs, compare all result ports, then drop both strobes.
    task automatic step_and_expect(input logic o, input logic [2:0] l, input logic [31:0] d, input string tag);
        logic lanes_ok;
        @(negedge clk);
        lanes_ok = 1'b1;
        for (int k = 0; k < LINES; k++) begin
            if (out_words[k*WORD_W +: WORD_W] !== d) lanes_ok = 1'b0;
        end
        check(out_valid === 1'b1, {tag, " R2 valid"}, 64'(out_valid), 64'd1);
        check(out_mask === (8'd1 << l), {tag, " R2 mask"}, 64'(out_mask), 64'(8'd1 << l));
        check(out_orient === o, {tag, " R2 orient"}, 64'(out_orient), 64'(o));
        check(lanes_ok, {tag, " R3 lanes"}, 64'(out_words[WORD_W-1:0]), 64'(d));
        wr_en = 1'b0;
        bc_en = 1'b0;
    endtask

    task automatic write_word(input logic o, input logic [2:0] l, input logic [3:0] i, input logic [31:0] d);
        set_write(o, l, i, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
        check(out_mask === '0, "R9 reset mask", 64'(out_mask), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1, R4, R5: load the table, then broadcast every entry
        for (int n = 0; n < NVEC; n++) begin
            write_word(VEC[n].o, VEC[n].l, VEC[n].i, VEC[n].d);
        end
        for (int n = 0; n < NVEC; n++) begin
            set_bcast(VEC[n].o, VEC[n].l, VEC[n].i);
            step_and_expect(VEC[n].o, VEC[n].l, VEC[n].d, $sformatf("R1 R4 R5 vec%0d", n));
        end

        // R8: idle cycle after the last request
        @(negedge clk);
        check(out_valid === 1'b0, "R8 idle valid", 64'(out_valid), 64'd0);
        check(out_mask === '0, "R8 idle mask", 64'(out_mask), 64'd0);

        // R6: write elsewhere while broadcasting row 3 index 5
        set_write(1'b0, 3'd2, 4'd2, 32'h2222_2222);
        set_bcast(1'b0, 3'd3, 4'd5);
        step_and_expect(1'b0, 3'd3, 32'h1234_5678, "R6 concurrent bcast");
        set_bcast(1'b0, 3'd2, 4'd2);
        step_and_expect(1'b0, 3'd2, 32'h2222_2222, "R6 concurrent write");

        // R7: same location in the same cycle returns old word first
        set_write(1'b0, 3'd3, 4'd5, 32'h9999_0000);
        set_bcast(1'b0, 3'd3, 4'd5);
        step_and_expect(1'b0, 3'd3, 32'h1234_5678, "R7 collision old");
        set_bcast(1'b0, 3'd3, 4'd5);
        step_and_expect(1'b0, 3'd3, 32'h9999_0000, "R7 collision new");

        // R4: column word untouched by the row rewrite above
        set_bcast(1'b1, 3'd3, 4'd5);
        step_and_expect(1'b1, 3'd3, 32'h8765_4321, "R4 column kept");

        // R10: strobe low, address and data driven
        wr_en = 1'b0; wr_orient = 1'b1; wr_line = 3'd3; wr_idx = 4'd5; wr_data = 32'h0BAD_0BAD;
        @(negedge clk);
        set_bcast(1'b1, 3'd3, 4'd5);
        step_and_expect(1'b1, 3'd3, 32'h8765_4321, "R10 no write");

        // R9: reset with a request pending at the same edge
        set_bcast(1'b1, 3'd7, 4'd0);
        rst = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9 reset pending valid", 64'(out_valid), 64'd0);
        check(out_mask === '0, "R9 reset pending mask", 64'(out_mask), 64'd0);
        bc_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule